// File: doc/BRIEF.md
# Linear frequency ramp generator

When a synchronizer loop leaves holdover, its frequency-control word must not jump from the held value to the newly acquired one. This block glides the word instead. A start strobe captures the held word, the wanted target word and a rate code. On every update tick after that, the output moves by a fixed increment toward the target. The direction of that increment follows the sign of the measured difference.

The number of ticks in the glide is set by the size of the difference and the chosen increment. The last tick is shortened so that the output lands exactly on the target. A one-cycle done strobe marks the arrival. The rate code picks one of forty increments that form a roughly geometric ladder. Loop bandwidth plays no part in the choice. Choosing the target word itself is left to the surrounding logic.

Top module: `freq_ramp`

## Requirements
- R1: While rst is high and in the first cycle after it, freq_out is 0, busy is 0 and done is 0.
- R2: A start while idle makes freq_out equal hold_freq on the next cycle. busy is then 1 when target_freq differs from hold_freq.
- R3: Each tick while busy moves freq_out by exactly one step toward the captured target. The move is upward when the target is larger and downward when it is smaller, and the output never overshoots.
- R4: While busy, a cycle without tick leaves freq_out unchanged. While idle, freq_out changes only on start.
- R5: On a tick where the remaining distance is at most one step, freq_out becomes the target and busy clears. done is high for exactly that one cycle.
- R6: A start with target_freq equal to the base value ends at once. On the next cycle done is 1, busy is 0 and freq_out holds the base value.
- R7: For codes 0 to 39 the step is (2 + code[0]) shifted left by code>>1, so code 0 gives 2 and code 39 gives 1572864. Any code of 40 or above uses the step of code 39.
- R8: A start while busy restarts the glide from the current freq_out toward the new target, using the new code. hold_freq is ignored in that case.
- R9: When start and tick arrive in the same cycle, start wins and no step is applied in that cycle.
- R10: The rate code is captured at start. Changes to rate_code during a glide do not alter the step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin (or restart) a glide |
| hold_freq | input | FW | Held frequency word, used as the starting point when idle |
| target_freq | input | FW | Frequency word to arrive at |
| rate_code | input | CODE_W | Increment selection, saturating above 39 |
| tick | input | 1 | Update strobe; one step per tick |
| freq_out | output | FW | Current frequency-control word |
| busy | output | 1 | A glide is in progress |
| done | output | 1 | One-cycle strobe on arrival |

## Verification
The assertions assume that the words are unsigned. They also assume that a glide never has to cross the wrap of the word. Every hold and target value in the stimulus therefore stays well below 2^32, and the step sums across the rate sweep stay far under the target used there. Ticks arrive in dense runs, in sparse patterns and together with start. Restarts come both mid-glide and with an unchanged target. Every output is compared each cycle with a behavioural model built from integers.

// File: rtl/freq_ramp_pkg.sv
package freq_ramp_pkg;

    typedef enum logic {
        RS_IDLE  = 1'b0,
        RS_GLIDE = 1'b1
    } ramp_state_e;

    // Increment ladder: two mantissas (2, 3) per octave.
    function automatic longint unsigned rate_step(input int idx);
        longint unsigned mant;
        mant = (idx % 2 == 0) ? 64'd2 : 64'd3;
        return mant << (idx / 2);
    endfunction

endpackage

// File: rtl/ramp_rate_lut.sv
module ramp_rate_lut #(
    parameter int FW        = 32,
    parameter int CODE_W    = 6,
    parameter int NUM_RATES = 40
) (
    input  logic [CODE_W-1:0] code,
    output logic [FW-1:0]     step
);
    localparam logic [CODE_W-1:0] TOP_CODE = CODE_W'(NUM_RATES - 1);

    logic [FW-1:0]     ladder [NUM_RATES];
    logic [CODE_W-1:0] idx;

    for (genvar g = 0; g < NUM_RATES; g++) begin : g_rung
        assign ladder[g] = FW'(freq_ramp_pkg::rate_step(g));
    end

    assign idx  = (code > TOP_CODE) ? TOP_CODE : code;
    assign step = ladder[idx];
endmodule

// File: rtl/ramp_dist.sv
module ramp_dist #(
    parameter int FW = 32
) (
    input  logic [FW-1:0] from_val,
    input  logic [FW-1:0] to_val,
    output logic [FW-1:0] mag,
    output logic          up
);
    assign up  = to_val > from_val;
    assign mag = up ? (to_val - from_val) : (from_val - to_val);
endmodule

// File: rtl/freq_ramp.sv
module freq_ramp #(
    parameter int FW        = 32,
    parameter int CODE_W    = 6,
    parameter int NUM_RATES = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [FW-1:0]     hold_freq,
    input  logic [FW-1:0]     target_freq,
    input  logic [CODE_W-1:0] rate_code,
    input  logic              tick,
    output logic [FW-1:0]     freq_out,
    output logic              busy,
    output logic              done
);
    import freq_ramp_pkg::*;

    ramp_state_e   state_q;
    logic [FW-1:0] freq_q;
    logic [FW-1:0] tgt_q;
    logic [FW-1:0] step_q;
    logic          done_q;

    logic [FW-1:0] base_val;
    logic [FW-1:0] new_step;
    logic [FW-1:0] rem_mag;
    logic          rem_up;
    logic          land;

    assign busy     = (state_q == RS_GLIDE);
    assign base_val = busy ? freq_q : hold_freq;

    ramp_rate_lut #(.FW(FW), .CODE_W(CODE_W), .NUM_RATES(NUM_RATES)) u_lut (
        .code (rate_code),
        .step (new_step)
    );

    ramp_dist #(.FW(FW)) u_rem (
        .from_val (freq_q),
        .to_val   (tgt_q),
        .mag      (rem_mag),
        .up       (rem_up)
    );

    assign land = (rem_mag <= step_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RS_IDLE;
            freq_q  <= '0;
            tgt_q   <= '0;
            step_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                freq_q <= base_val;
                tgt_q  <= target_freq;
                step_q <= new_step;
                if (base_val == target_freq) begin
                    state_q <= RS_IDLE;
                    done_q  <= 1'b1;
                end else begin
                    state_q <= RS_GLIDE;
                end
            end else if (busy && tick) begin
                if (land) begin
                    freq_q  <= tgt_q;
                    state_q <= RS_IDLE;
                    done_q  <= 1'b1;
                end else if (rem_up) begin
                    freq_q <= freq_q + step_q;
                end else begin
                    freq_q <= freq_q - step_q;
                end
            end
        end
    end

    assign freq_out = freq_q;
    assign done     = done_q;
endmodule

// File: rtl/freq_ramp_chk.sv
module freq_ramp_chk #(
    parameter int FW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          tick,
    input logic          busy,
    input logic          done,
    input logic [FW-1:0] freq_out,
    input logic [FW-1:0] tgt_q,
    input logic [FW-1:0] step_q
);
    AST_LAND_EXACT: assert property (@(posedge clk) disable iff (rst)
        done |-> freq_out == tgt_q); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done && !start |=> !done); // R5

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R6

    AST_WAIT_TICK: assert property (@(posedge clk) disable iff (rst)
        busy && !tick && !start |=> $stable(freq_out) && busy); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !busy && !start |=> $stable(freq_out)); // R4

    AST_FULL_STEP: assert property (@(posedge clk) disable iff (rst)
        busy && tick && !start |=>
            (busy -> ((freq_out - $past(freq_out)) == step_q ||
                      ($past(freq_out) - freq_out) == step_q))); // R3

    AST_START_WINS: assert property (@(posedge clk) disable iff (rst)
        start && tick && busy |=> freq_out == $past(freq_out)); // R9
endmodule

bind freq_ramp freq_ramp_chk #(.FW(FW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .tick     (tick),
    .busy     (busy),
    .done     (done),
    .freq_out (freq_out),
    .tgt_q    (tgt_q),
    .step_q   (step_q)
);

// File: tb/sim_freq_ramp.sv
module sim_freq_ramp;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] hold_freq = '0;
    logic [31:0] target_freq = '0;
    logic [5:0]  rate_code = '0;
    logic        tick = 1'b0;
    logic [31:0] freq_out;
    logic        busy;
    logic        done;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    string cur_req = "R1";

    longint m_freq = 0, m_tgt = 0, m_step = 0;
    bit     m_busy = 0, m_done = 0;

    always #4 clk = ~clk;

    freq_ramp u0 (
        .clk(clk), .rst(rst), .start(start), .hold_freq(hold_freq),
        .target_freq(target_freq), .rate_code(rate_code), .tick(tick),
        .freq_out(freq_out), .busy(busy), .done(done)
    );

    function automatic longint mstep(int c);
        int k;
        k = (c > 39) ? 39 : c;
        return ((k % 2 == 0) ? 2 : 3) * (longint'(1) << (k / 2));
    endfunction

    // Behavioural reference, updated on each rising edge.
    always @(posedge clk) begin
        longint base, rem;
        if (rst) begin
            m_freq = 0; m_tgt = 0; m_step = 0; m_busy = 0; m_done = 0;
        end else begin
            m_done = 0;
            if (start) begin
                base   = m_busy ? m_freq : longint'(hold_freq);
                m_freq = base;
                m_tgt  = longint'(target_freq);
                m_step = mstep(int'(rate_code));
                if (base == m_tgt) begin m_busy = 0; m_done = 1; end
                else m_busy = 1;
            end else if (m_busy && tick) begin
                rem = m_tgt - m_freq;
                if (rem < 0) rem = -rem;
                if (rem <= m_step) begin
                    m_freq = m_tgt; m_busy = 0; m_done = 1;
                end else if (m_tgt > m_freq) m_freq = m_freq + m_step;
                else m_freq = m_freq - m_step;
            end
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (longint'(freq_out) != m_freq || busy != m_busy || done != m_done) begin
                errors++;
                $display("FAIL %s model: freq=%0d busy=%0b done=%0b expected freq=%0d busy=%0b done=%0b",
                         cur_req, freq_out, busy, done, m_freq, m_busy, m_done);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic kick(logic [31:0] h, logic [31:0] t, logic [5:0] c);
        hold_freq = h; target_freq = t; rate_code = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_to_done(int every);
        for (int i = 0; i < 5000; i++) begin
            tick = (i % every == 0);
            @(negedge clk);
            if (done) begin tick = 1'b0; return; end
        end
        tick = 1'b0;
    endtask

    initial begin
        longint f0;
        repeat (3) @(negedge clk);
        chk("R1 reset freq", freq_out, 0);
        chk("R1 reset busy", busy, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset done", done, 0);
        chk("R1 after reset freq", freq_out, 0);

        // Upward glide, dense ticks
        cur_req = "R2";
        kick(32'd1000, 32'd1101, 6'd0);
        chk("R2 start value", freq_out, 1000);
        chk("R2 busy", busy, 1);
        cur_req = "R3";
        tick = 1'b1; @(negedge clk); tick = 1'b0;
        chk("R3 one up step", freq_out, 1002);
        cur_req = "R5";
        run_to_done(1);
        chk("R5 landed", freq_out, 1101);
        chk("R5 done", done, 1);
        @(negedge clk);
        chk("R5 done single", done, 0);

        // Downward glide, sparse ticks
        cur_req = "R4";
        kick(32'd5000, 32'd4000, 6'd5);
        @(negedge clk); @(negedge clk);
        chk("R4 no tick hold", freq_out, 5000);
        tick = 1'b1; @(negedge clk); tick = 1'b0;
        chk("R3 down step", freq_out, 5000 - 12);
        run_to_done(3);
        chk("R5 landed down", freq_out, 4000);

        // Zero difference
        cur_req = "R6";
        kick(32'd777, 32'd777, 6'd3);
        chk("R6 done at once", done, 1);
        chk("R6 not busy", busy, 0);
        chk("R6 value", freq_out, 777);
        @(negedge clk);

        // Rate ladder sweep, including saturated codes
        cur_req = "R7";
        for (int c = 0; c < 46; c++) begin
            kick(32'd0, 32'h4000_0000, 6'(c));
            f0 = longint'(freq_out);
            tick = 1'b1; @(negedge clk); tick = 1'b0;
            chk($sformatf("R7 step code %0d", c), longint'(freq_out) - f0, mstep(c));
        end
        run_to_done(1);
        @(negedge clk);

        // Restart while busy
        cur_req = "R8";
        kick(32'd0, 32'd10000, 6'd4);
        tick = 1'b1; repeat (10) @(negedge clk); tick = 1'b0;
        chk("R8 before restart", freq_out, 80);
        kick(32'd99999, 32'd50, 6'd1);
        chk("R8 restart keeps value", freq_out, 80);
        tick = 1'b1; @(negedge clk); tick = 1'b0;
        chk("R8 new step down", freq_out, 77);
        run_to_done(2);
        chk("R8 landed", freq_out, 50);

        // Start and tick together
        cur_req = "R9";
        hold_freq = 32'd300; target_freq = 32'd900; rate_code = 6'd6;
        start = 1'b1; tick = 1'b1;
        @(negedge clk);
        start = 1'b0; tick = 1'b0;
        chk("R9 start beats tick", freq_out, 300);

        // Code change mid-glide
        cur_req = "R10";
        rate_code = 6'd30;
        tick = 1'b1; @(negedge clk); tick = 1'b0;
        chk("R10 latched step", freq_out, 316);
        run_to_done(1);
        chk("R10 landed", freq_out, 900);
        repeat (3) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule